// File: doc/BRIEF.md
# Capture-Compare Timer with Event Flags

This block is a free-running up-counter that advances on an external prescaler tick. A reference register provides an output-compare point. When the counter holds the reference value and the next tick arrives, the counter restarts at zero and a reference flag is raised. The period is therefore reference+1 tick intervals.

An external capture pin passes through a synchronizer. A selectable edge on the synchronized signal copies the counter into a capture register and raises a capture flag. Software clears either flag by writing one to it.

Each flag can raise one of two requests. A single routing bit selects between a level interrupt and a DMA request. A DMA acknowledge pulse drops the DMA request by clearing the flags routed to DMA.

Top module: `cct_timer`

## Requirements
- R1: Register map on `addr_i`: 0 = control (bits [1:0] edge mode, bit 2 reference-request enable, bit 3 DMA route), 1 = reference (read/write), 2 = capture value (read-only), 3 = counter (read-only), 4 = event flags (bit 1 reference flag, bit 0 capture flag, every higher bit reads zero). Addresses 5 to 7 read zero and ignore writes. Writes to addresses 2 and 3 have no effect.
- R2: A write to the event register clears each flag whose data bit is 1. A flag whose data bit is 0 stays as it was.
- R3: On each tick the counter increments. If the counter equals the reference value when a tick arrives, the counter becomes 0 and the reference flag is set on that same edge. A reference value of N therefore flags every N+1 ticks.
- R4: The capture pin goes through two synchronizer flops, and edges are detected on the second stage. Edge mode encodes capture as follows: 00 no capture, 01 rising edge, 10 falling edge, 11 either edge. A flag set by a pin change becomes visible 3 clock edges after the pin is sampled.
- R5: A capture event copies the counter value of that cycle into the capture register and sets the capture flag.
- R6: With DMA route 0, a set capture flag (edge mode not 00) drives `irq_o`. With DMA route 1, it drives `dma_req_o` instead.
- R7: A set reference flag raises a request only when reference-request enable is 1. The DMA route bit then picks the interrupt or the DMA request. The flag itself still sets when the enable is 0.
- R8: With DMA route 1, a `dma_ack_i` pulse clears the capture flag. It also clears the reference flag if reference-request enable is 1. With DMA route 0, the acknowledge has no effect.
- R9: If a flag's event and its clear (a write of one or an acknowledge) fall in the same cycle, the flag ends up set.
- R10: `irq_o` is a level that is high exactly while a set flag is enabled and routed to the interrupt. `dma_req_o` is the same for DMA.
- R11: After reset the counter, capture register, control register and flags are zero, the reference register holds all ones, and both requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaler tick; counter advances on cycles where it is high |
| cap_pin_i | input | 1 | Asynchronous capture input |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for `addr_i` (combinational) |
| dma_ack_i | input | 1 | DMA acknowledge pulse |
| irq_o | output | 1 | Level interrupt request |
| dma_req_o | output | 1 | DMA request |

## Verification
A wrong counter or a lost wrap appears on the counter read address at once. It also shifts the reference flag, so the interrupt rises on the wrong tick, at least one tick interval away from the expected edge. A wrong synchronizer depth or a wrong edge decode moves or suppresses the capture flag, and that is visible within three or four cycles of a pin change. A bad clear or routing decision shows on `irq_o` or `dma_req_o` in the cycle right after the write or acknowledge. Because of this, the outputs are compared every cycle against a model built from the requirements.

// File: rtl/cct_pkg.sv
package cct_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_REF  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CAPT = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_EVT  = 3'd4;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

    // bit 3 dma route, bit 2 reference request enable, bits [1:0] edge mode
    typedef struct packed {
        logic       dma_sel;
        logic       ref_en;
        edge_mode_e edge_mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cct_cap_sync.sv
module cct_cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] sh;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[DEPTH-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // last synchronizer stage against one extra history flop
    assign rise_o =  s_q.sh[STAGES-1] & ~s_q.sh[STAGES];
    assign fall_o = ~s_q.sh[STAGES-1] &  s_q.sh[STAGES];
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [W-1:0] ref_i,
    output logic [W-1:0] cnt_o,
    output logic         match_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;
    logic hit;

    always_comb begin
        hit = tick_i && (c_q.cnt == ref_i);
        c_d = c_q;
        if (tick_i) begin
            if (hit) c_d.cnt = '0;
            else     c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_o   = c_q.cnt;
    assign match_o = hit;
endmodule

// File: rtl/cct_route.sv
module cct_route (
    input  logic f_ref_i,
    input  logic f_cap_i,
    input  logic cap_on_i,
    input  logic ref_en_i,
    input  logic dma_sel_i,
    output logic irq_o,
    output logic dma_req_o
);
    logic live;

    always_comb begin
        live      = (f_cap_i & cap_on_i) | (f_ref_i & ref_en_i);
        irq_o     = live & ~dma_sel_i;
        dma_req_o = live &  dma_sel_i;
    end
endmodule

// File: rtl/cct_timer.sv
module cct_timer
    import cct_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cap_pin_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    input  logic              dma_ack_i,
    output logic              irq_o,
    output logic              dma_req_o
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] ref_val;
        logic [CNT_W-1:0] capt;
        logic             f_ref;
        logic             f_cap;
    } regs_t;

    regs_t st_d, st_q;

    logic [CNT_W-1:0] cnt;
    logic             ref_ev;
    logic             rise, fall;
    logic             cap_ev;
    logic             wr_evt;
    logic             clr_cap, clr_ref;
    logic             cap_on;

    // probes for the bound checker
    logic [CNT_W-1:0] ref_val;
    logic [CNT_W-1:0] capt;
    logic             f_ref, f_cap, dma_sel;
    edge_mode_e       edge_mode;

    cct_cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (cap_pin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    cct_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .ref_i   (st_q.ref_val),
        .cnt_o   (cnt),
        .match_o (ref_ev)
    );

    assign cap_on = (st_q.ctrl.edge_mode != EDGE_OFF);

    cct_route u_route (
        .f_ref_i   (st_q.f_ref),
        .f_cap_i   (st_q.f_cap),
        .cap_on_i  (cap_on),
        .ref_en_i  (st_q.ctrl.ref_en),
        .dma_sel_i (st_q.ctrl.dma_sel),
        .irq_o     (irq_o),
        .dma_req_o (dma_req_o)
    );

    always_comb begin
        unique case (st_q.ctrl.edge_mode)
            EDGE_OFF:  cap_ev = 1'b0;
            EDGE_RISE: cap_ev = rise;
            EDGE_FALL: cap_ev = fall;
            default:   cap_ev = rise | fall;
        endcase
    end

    always_comb begin
        wr_evt  = wr_en_i && (addr_i == A_EVT);
        clr_cap = (wr_evt && wdata_i[0]) || (dma_ack_i && st_q.ctrl.dma_sel);
        clr_ref = (wr_evt && wdata_i[1]) ||
                  (dma_ack_i && st_q.ctrl.dma_sel && st_q.ctrl.ref_en);

        st_d = st_q;
        if (wr_en_i && addr_i == A_CTRL) st_d.ctrl    = ctrl_t'(wdata_i[CTRL_W-1:0]);
        if (wr_en_i && addr_i == A_REF)  st_d.ref_val = wdata_i;
        if (cap_ev)                      st_d.capt    = cnt;
        // a fresh event outranks a clear in the same cycle
        st_d.f_cap = cap_ev | (st_q.f_cap & ~clr_cap);
        st_d.f_ref = ref_ev | (st_q.f_ref & ~clr_ref);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl    <= '0;
            st_q.ref_val <= '1;
            st_q.capt    <= '0;
            st_q.f_ref   <= 1'b0;
            st_q.f_cap   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_CTRL:  rdata_o[CTRL_W-1:0] = st_q.ctrl;
            A_REF:   rdata_o             = st_q.ref_val;
            A_CAPT:  rdata_o             = st_q.capt;
            A_CNT:   rdata_o             = cnt;
            A_EVT:   rdata_o[1:0]        = {st_q.f_ref, st_q.f_cap};
            default: rdata_o             = '0;
        endcase
    end

    assign ref_val   = st_q.ref_val;
    assign capt      = st_q.capt;
    assign f_ref     = st_q.f_ref;
    assign f_cap     = st_q.f_cap;
    assign dma_sel   = st_q.ctrl.dma_sel;
    assign edge_mode = st_q.ctrl.edge_mode;
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk
    import cct_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic [W-1:0]      cnt,
    input logic [W-1:0]      ref_val,
    input logic [W-1:0]      capt,
    input logic              f_ref,
    input logic              f_cap,
    input logic              cap_ev,
    input logic              dma_sel,
    input edge_mode_e        edge_mode,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [W-1:0]      wdata_i,
    input logic [W-1:0]      rdata_o,
    input logic              irq_o,
    input logic              dma_req_o
);
    assert_evt_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == A_EVT) |-> (rdata_o[W-1:2] == '0));

    assert_w1c_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_EVT && wdata_i[0] && !cap_ev) |=> !f_cap);

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cnt == ref_val) |=> (cnt == '0 && f_ref));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i) |=> $stable(cnt));

    assert_cap_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode == EDGE_OFF) |=> $stable(capt));

    assert_cap_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev |=> (capt == $past(cnt)));

    assert_route_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !dma_sel);

    assert_route_dma_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o |-> dma_sel);

    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev |=> f_cap);

    assert_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || dma_req_o) |-> (f_ref || f_cap));

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_o, dma_req_o}));
endmodule

bind cct_timer cct_timer_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .cnt       (cnt),
    .ref_val   (ref_val),
    .capt      (capt),
    .f_ref     (f_ref),
    .f_cap     (f_cap),
    .cap_ev    (cap_ev),
    .dma_sel   (dma_sel),
    .edge_mode (edge_mode),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o),
    .dma_req_o (dma_req_o)
);

// File: tb/cct_timer_tb.sv
module cct_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0, cap_pin_i = 1'b0, wr_en_i = 1'b0, dma_ack_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        irq_o, dma_req_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    cct_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cap_pin_i(cap_pin_i),
        .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .dma_ack_i(dma_ack_i), .irq_o(irq_o), .dma_req_o(dma_req_o)
    );

    // requirement-level model
    logic [15:0] m_cnt, m_ref, m_capt;
    logic [3:0]  m_ctrl;
    logic        m_fref, m_fcap, m_s1, m_s2, m_s3;

    always @(posedge clk or negedge rst_n) begin
        logic r, f, cev, rev, clrc, clrr;
        if (!rst_n) begin
            m_cnt = 0; m_ref = 16'hFFFF; m_capt = 0; m_ctrl = 0;
            m_fref = 0; m_fcap = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            r    = m_s2 & ~m_s3;
            f    = ~m_s2 & m_s3;
            cev  = (m_ctrl[1:0] == 2'b01 && r) || (m_ctrl[1:0] == 2'b10 && f) ||
                   (m_ctrl[1:0] == 2'b11 && (r || f));
            rev  = tick_i && (m_cnt == m_ref);
            clrc = (wr_en_i && addr_i == 3'd4 && wdata_i[0]) || (dma_ack_i && m_ctrl[3]);
            clrr = (wr_en_i && addr_i == 3'd4 && wdata_i[1]) ||
                   (dma_ack_i && m_ctrl[3] && m_ctrl[2]);
            if (cev) m_capt = m_cnt;
            if (tick_i) m_cnt = rev ? 16'd0 : m_cnt + 16'd1;
            m_fcap = cev | (m_fcap & ~clrc);
            m_fref = rev | (m_fref & ~clrr);
            if (wr_en_i && addr_i == 3'd0) m_ctrl = wdata_i[3:0];
            if (wr_en_i && addr_i == 3'd1) m_ref  = wdata_i;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_pin_i;
        end
    end

    function automatic logic m_live();
        return (m_fcap && m_ctrl[1:0] != 2'b00) || (m_fref && m_ctrl[2]);
    endfunction

    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd0:    return {12'd0, m_ctrl};
            3'd1:    return m_ref;
            3'd2:    return m_capt;
            3'd3:    return m_cnt;
            3'd4:    return {14'd0, m_fref, m_fcap};
            default: return 16'd0;
        endcase
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic tk, input logic pn, input logic we, input logic [2:0] a,
                       input logic [15:0] wd, input logic ak, output logic [15:0] rd);
        @(negedge clk);
        chk({15'd0, irq_o},     {15'd0, m_live() & ~m_ctrl[3]}, "R10 irq level (R6 R7 routing)");
        chk({15'd0, dma_req_o}, {15'd0, m_live() &  m_ctrl[3]}, "R10 dma level (R6 R8)");
        tick_i = tk; cap_pin_i = pn; wr_en_i = we; addr_i = a; wdata_i = wd; dma_ack_i = ak;
        #1;
        rd = rdata_o;
        case (a)
            3'd3:    chk(rd, m_read(a), "R3 counter read");
            3'd2:    chk(rd, m_read(a), "R5 capture read");
            default: chk(rd, m_read(a), "R1 register read");
        endcase
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        logic [15:0] rd;
        cyc(1'b0, cap_pin_i, 1'b1, a, d, 1'b0, rd);
    endtask

    task automatic rdreg(input logic [2:0] a, output logic [15:0] rd);
        cyc(1'b0, cap_pin_i, 1'b0, a, 16'd0, 1'b0, rd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd, cval;
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state
        rdreg(3'd3, rd); chk(rd, 16'd0, "R11 counter after reset");
        rdreg(3'd4, rd); chk(rd, 16'd0, "R11 flags after reset");
        rdreg(3'd1, rd); chk(rd, 16'hFFFF, "R11 reference after reset");
        rdreg(3'd0, rd); chk(rd, 16'd0, "R11 control after reset");
        chk({15'd0, irq_o | dma_req_o}, 16'd0, "R11 requests low");

        // R1 unused address and read-only registers ignore writes
        wr(3'd6, 16'h1234); rdreg(3'd6, rd); chk(rd, 16'd0, "R1 unused address");
        wr(3'd3, 16'h0055); rdreg(3'd3, rd); chk(rd, 16'd0, "R1 counter read-only");

        // R3 period ref+1, R7 enabled reference -> irq
        wr(3'd0, 16'h0004); wr(3'd1, 16'd3);
        repeat (3) cyc(1'b1, 1'b0, 1'b0, 3'd4, 16'd0, 1'b0, rd);
        rdreg(3'd4, rd); chk(rd, 16'd0, "R3 no flag before ref+1 ticks");
        cyc(1'b1, 1'b0, 1'b0, 3'd4, 16'd0, 1'b0, rd);
        rdreg(3'd4, rd); chk(rd, 16'd2, "R3 flag after ref+1 ticks");
        rdreg(3'd3, rd); chk(rd, 16'd0, "R3 counter restarts at zero");
        chk({15'd0, irq_o}, 16'd1, "R7 enabled reference raises irq");

        // R2 write-one-to-clear
        wr(3'd4, 16'h0001); rdreg(3'd4, rd); chk(rd, 16'd2, "R2 zero bit leaves flag");
        wr(3'd4, 16'h0002); rdreg(3'd4, rd); chk(rd, 16'd0, "R2 one bit clears flag");
        chk({15'd0, irq_o}, 16'd0, "R10 irq drops with flag");

        // R7 disabled reference: flag sets, no request
        wr(3'd0, 16'h0000);
        repeat (4) cyc(1'b1, 1'b0, 1'b0, 3'd3, 16'd0, 1'b0, rd);
        rdreg(3'd4, rd); chk(rd, 16'd2, "R7 flag sets while disabled");
        chk({15'd0, irq_o | dma_req_o}, 16'd0, "R7 no request while disabled");
        wr(3'd4, 16'h0002);

        // R9 event wins over clear in same cycle
        wr(3'd0, 16'h0004);
        repeat (3) cyc(1'b1, 1'b0, 1'b0, 3'd3, 16'd0, 1'b0, rd);
        cyc(1'b1, 1'b0, 1'b1, 3'd4, 16'h0002, 1'b0, rd);
        rdreg(3'd4, rd); chk(rd, 16'd2, "R9 event beats clear");
        wr(3'd4, 16'h0002);

        // R4/R5 capture on rising edge with two-flop latency
        wr(3'd0, 16'h0001);
        repeat (2) cyc(1'b1, 1'b0, 1'b0, 3'd3, 16'd0, 1'b0, rd);
        rdreg(3'd3, cval);
        cyc(1'b0, 1'b1, 1'b0, 3'd4, 16'd0, 1'b0, rd);
        cyc(1'b0, 1'b1, 1'b0, 3'd4, 16'd0, 1'b0, rd);
        cyc(1'b0, 1'b1, 1'b0, 3'd4, 16'd0, 1'b0, rd); chk(rd, 16'd0, "R4 synchronizer latency");
        cyc(1'b0, 1'b1, 1'b0, 3'd4, 16'd0, 1'b0, rd); chk(rd, 16'd1, "R5 capture flag set");
        rdreg(3'd2, rd); chk(rd, cval, "R5 captured counter value");
        chk({15'd0, irq_o}, 16'd1, "R6 capture routed to irq");
        wr(3'd4, 16'h0001);
        repeat (4) cyc(1'b0, 1'b0, 1'b0, 3'd4, 16'd0, 1'b0, rd);
        chk(rd, 16'd0, "R4 falling edge ignored in rising mode");

        // R4 falling mode
        wr(3'd0, 16'h0002);
        repeat (5) cyc(1'b0, 1'b1, 1'b0, 3'd4, 16'd0, 1'b0, rd);
        chk(rd, 16'd0, "R4 rising edge ignored in falling mode");
        repeat (5) cyc(1'b0, 1'b0, 1'b0, 3'd4, 16'd0, 1'b0, rd);
        chk(rd, 16'd1, "R4 falling edge captured");
        wr(3'd4, 16'h0001);

        // R6/R8 DMA route and acknowledge
        wr(3'd0, 16'h0009);
        repeat (5) cyc(1'b0, 1'b1, 1'b0, 3'd4, 16'd0, 1'b0, rd);
        chk({15'd0, dma_req_o}, 16'd1, "R6 capture routed to dma");
        chk({15'd0, irq_o}, 16'd0, "R6 irq quiet when routed to dma");
        cyc(1'b0, 1'b1, 1'b0, 3'd4, 16'd0, 1'b1, rd);
        rdreg(3'd4, rd); chk(rd, 16'd0, "R8 acknowledge clears flag");
        chk({15'd0, dma_req_o}, 16'd0, "R8 dma request dropped");

        // R8 acknowledge ignored on interrupt route
        wr(3'd0, 16'h0003);
        repeat (5) cyc(1'b0, 1'b0, 1'b0, 3'd4, 16'd0, 1'b0, rd);
        cyc(1'b0, 1'b0, 1'b0, 3'd4, 16'd0, 1'b1, rd);
        rdreg(3'd4, rd); chk(rd, 16'd1, "R8 acknowledge ignored on irq route");
        wr(3'd4, 16'h0003);

        // constrained random phase, model compared every cycle
        for (int i = 0; i < 4000; i++) begin
            logic tk, pn, we, ak;
            logic [2:0]  a;
            logic [15:0] d;
            tk = ($urandom % 3) == 0;
            pn = (($urandom % 6) == 0) ? ~cap_pin_i : cap_pin_i;
            we = ($urandom % 8) == 0;
            ak = ($urandom % 10) == 0;
            a  = 3'($urandom % 8);
            if (a == 3'd1)      d = 16'($urandom % 16);
            else if (a == 3'd0) d = 16'($urandom % 16);
            else                d = 16'($urandom);
            cyc(tk, pn, we, a, d, ak, rd);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule